// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Bit Rate

This block turns 8-bit bytes into frames on an asynchronous serial line. A free-running divider makes a single-cycle bit-rate tick. A 2-bit selector picks one of four tick periods, and each period is a power of two in clocks. A producer sees `tx_ready` high, then raises `tx_en` for one cycle with the byte on `tx_byte`. The block stores the byte and sends it as a start bit, eight data bits and one or two stop bits. A parameter sets the number of stop bits.

The tick period in clocks is `2**(BASE_LOG2 + baud_sel)`. With the default `BASE_LOG2 = 6` the period is 64 clocks at selector 00. With a clock at 64 times 115200 Hz, that gives 115200 baud. Each higher selector code halves the rate. The frame waits for the next tick to start, so every bit edge lines up with a tick. The line sits high between frames.

Top module: `serial_byte_tx`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `tx_line` is 1 and `tx_ready` is 1. Reset also clears the divider count and the tick.
- R2: The tick period is `2**(BASE_LOG2 + baud_sel)` clocks. Selector 00 is the fastest, and each higher code doubles the period. The default `BASE_LOG2 = 6` gives periods of 64, 128, 256 and 512 clocks.
- R3: A frame is a 0 start bit followed by the 8 data bits, least significant bit first. Each bit lasts exactly one tick period.
- R4: The data bits are followed by `STOP_BITS` stop bits, each at level 1 and one tick period long. `STOP_BITS` may be 1 or 2 and defaults to 2.
- R5: A byte is accepted on a clock edge where `tx_en` and `tx_ready` are both 1. `tx_ready` is 0 from the next cycle onward. It returns to 1 on the same edge at which the last stop bit period ends.
- R6: When `tx_en` is high while `tx_ready` is 0, the block ignores it. The frame in progress is unchanged, and no extra frame follows.
- R7: `tx_line` is 1 whenever `tx_ready` is 1. `tx_line` changes only on the clock edge that follows a tick.
- R8: The tick is high for exactly one clock per period.
- R9: The start bit begins between 1 and one tick period of clocks after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_sel | input | 2 | Tick period selector, 00 is the fastest |
| tx_en | input | 1 | Offer `tx_byte` to the transmitter |
| tx_byte | input | 8 | Byte to send |
| tx_ready | output | 1 | High when a new byte can be accepted |
| tx_line | output | 1 | Serial line output, idles high |

## Verification
The bench sets `BASE_LOG2 = 2`, so the four selector codes give tick periods of 4, 8, 16 and 32 clocks. This keeps every frame at every rate short enough to compare sample by sample. Two instances are built, one with two stop bits and one with a single stop bit, so both frame lengths and both end-of-frame edges for ready are covered. At every rate the bench sends bytes with all-zero, all-one, alternating and single-bit patterns. It also offers a second byte while a frame is in progress.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARM,
    PH_START,
    PH_DATA,
    PH_STOP
  } phase_t;

  // Last count value of the divider before it wraps.
  function automatic int unsigned tick_wrap(input int unsigned base_log2,
                                            input logic [1:0] sel);
    return (32'd1 << (base_log2 + int'(sel))) - 32'd1;
  endfunction

  // Number of bit periods in one frame.
  function automatic int unsigned frame_bits(input int unsigned data_w,
                                             input int unsigned stops);
    return 1 + data_w + stops;
  endfunction

endpackage

// File: rtl/sbt_tick_gen.sv
module sbt_tick_gen #(
  parameter int unsigned BASE_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  import sbt_pkg::*;

  localparam int unsigned CW = BASE_LOG2 + 3;

  logic [CW-1:0] count_q;
  logic [CW-1:0] wrap_at;
  logic          at_wrap;

  assign wrap_at = CW'(tick_wrap(BASE_LOG2, sel));
  // Use >= so that a smaller period selected mid-count still wraps at once.
  assign at_wrap = (count_q >= wrap_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      tick    <= 1'b0;
    end else if (at_wrap) begin
      count_q <= '0;
      tick    <= 1'b1;
    end else begin
      count_q <= count_q + 1'b1;
      tick    <= 1'b0;
    end
  end

endmodule

// File: rtl/sbt_framer.sv
module sbt_framer #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              offer,
  input  logic [DATA_W-1:0] byte_in,
  output logic              ready,
  output logic              accept,
  output logic              frame_done,
  output logic              line
);
  import sbt_pkg::*;

  localparam int unsigned IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned STOP_W = (STOP_BITS > 1) ? $clog2(STOP_BITS) : 1;
  localparam logic [IDX_W-1:0]  LAST_BIT  = IDX_W'(DATA_W - 1);
  localparam logic [STOP_W-1:0] LAST_STOP = STOP_W'(STOP_BITS - 1);

  phase_t              phase_q;
  logic [DATA_W-1:0]   shift_q;
  logic [IDX_W-1:0]    bit_q;
  logic [STOP_W-1:0]   stop_q;
  logic                line_q;

  assign ready      = (phase_q == PH_IDLE);
  assign accept     = offer && ready;
  assign frame_done = tick && (phase_q == PH_STOP) && (stop_q == LAST_STOP);
  assign line       = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      shift_q <= '0;
      bit_q   <= '0;
      stop_q  <= '0;
      line_q  <= 1'b1;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            shift_q <= byte_in;
            phase_q <= PH_ARM;
          end
        end
        PH_ARM: begin
          if (tick) begin
            line_q  <= 1'b0;
            phase_q <= PH_START;
          end
        end
        PH_START: begin
          if (tick) begin
            line_q  <= shift_q[0];
            shift_q <= shift_q >> 1;
            bit_q   <= '0;
            phase_q <= PH_DATA;
          end
        end
        PH_DATA: begin
          if (tick) begin
            if (bit_q == LAST_BIT) begin
              line_q  <= 1'b1;
              stop_q  <= '0;
              phase_q <= PH_STOP;
            end else begin
              line_q  <= shift_q[0];
              shift_q <= shift_q >> 1;
              bit_q   <= bit_q + 1'b1;
            end
          end
        end
        PH_STOP: begin
          if (tick) begin
            if (stop_q == LAST_STOP) begin
              phase_q <= PH_IDLE;
            end else begin
              stop_q <= stop_q + 1'b1;
            end
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          line_q  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/serial_byte_tx.sv
module serial_byte_tx #(
  parameter int unsigned BASE_LOG2 = 6,
  parameter int unsigned STOP_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] baud_sel,
  input  logic       tx_en,
  input  logic [7:0] tx_byte,
  output logic       tx_ready,
  output logic       tx_line
);
  localparam int unsigned DATA_W = 8;

  // Internal events brought out as named nets for the checker.
  logic baud_tick;
  logic byte_accept;
  logic frame_done;

  sbt_tick_gen #(
    .BASE_LOG2(BASE_LOG2)
  ) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (baud_sel),
    .tick (baud_tick)
  );

  sbt_framer #(
    .DATA_W   (DATA_W),
    .STOP_BITS(STOP_BITS)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .offer     (tx_en),
    .byte_in   (tx_byte),
    .ready     (tx_ready),
    .accept    (byte_accept),
    .frame_done(frame_done),
    .line      (tx_line)
  );

endmodule

// File: rtl/sbt_chk.sv
module sbt_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic tx_en,
  input logic tx_ready,
  input logic tx_line,
  input logic byte_accept,
  input logic frame_done
);

  // R8
  single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  // R7
  line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_line) |-> $past(baud_tick));

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_line);

  // R5
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_accept |=> !tx_ready);

  // R5
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(frame_done) && $past(baud_tick));

  // R6
  fall_needs_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_en));

endmodule

bind serial_byte_tx sbt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_tick  (baud_tick),
  .tx_en      (tx_en),
  .tx_ready   (tx_ready),
  .tx_line    (tx_line),
  .byte_accept(byte_accept),
  .frame_done (frame_done)
);

// File: tb/sim_serial_byte_tx.sv
`timescale 1ns/1ps
module sim_serial_byte_tx;

  localparam int BL = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       en_a [2];
  logic [7:0] dat_a [2];
  wire        line_w [2];
  wire        ready_w [2];

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  serial_byte_tx #(.BASE_LOG2(BL), .STOP_BITS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_sel(sel), .tx_en(en_a[0]),
    .tx_byte(dat_a[0]), .tx_ready(ready_w[0]), .tx_line(line_w[0]));

  serial_byte_tx #(.BASE_LOG2(BL), .STOP_BITS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .baud_sel(sel), .tx_en(en_a[1]),
    .tx_byte(dat_a[1]), .tx_ready(ready_w[1]), .tx_line(line_w[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int w, input logic [7:0] b, input int p,
                           input int s, input bit poke);
    int n;
    @(negedge clk);
    chk(ready_w[w] == 1'b1, "R5 ready before offer", int'(ready_w[w]), 1);
    en_a[w] = 1'b1;
    dat_a[w] = b;
    @(negedge clk);
    en_a[w] = 1'b0;
    chk(ready_w[w] == 1'b0, "R5 ready low after accept", int'(ready_w[w]), 0);
    n = 0;
    while (line_w[w] !== 1'b0 && n <= p + 2) begin
      @(negedge clk);
      n++;
    end
    chk(n >= 1 && n <= p, "R9 start latency (R8 one tick per period)", n, p);
    for (int bn = 0; bn < 9 + s; bn++) begin
      logic exp_bit;
      bit ok;
      int bad_val;
      exp_bit = (bn == 0) ? 1'b0 : (bn <= 8) ? b[bn-1] : 1'b1;
      ok = 1'b1;
      bad_val = int'(exp_bit);
      for (int j = 0; j < p; j++) begin
        if (bn > 0 || j > 0) @(negedge clk);
        if (poke && bn == 2 && j == 0) begin
          en_a[w] = 1'b1;
          dat_a[w] = ~b;
        end
        if (poke && bn == 2 && j == 1) en_a[w] = 1'b0;
        if (line_w[w] !== exp_bit || ready_w[w] !== 1'b0) begin
          ok = 1'b0;
          bad_val = int'(line_w[w]);
        end
      end
      if (bn == 0)
        chk(ok, "R3 start bit level and R2 period", bad_val, int'(exp_bit));
      else if (bn <= 8)
        chk(ok, "R3 data bit LSB first, R7 tick aligned", bad_val, int'(exp_bit));
      else
        chk(ok, "R4 stop bit", bad_val, int'(exp_bit));
    end
    @(negedge clk);
    chk(ready_w[w] == 1'b1 && line_w[w] == 1'b1, "R5 ready back at end of last stop",
        int'({ready_w[w], line_w[w]}), 3);
    if (poke) begin
      bit quiet;
      quiet = 1'b1;
      for (int k = 0; k < 3 * p; k++) begin
        @(negedge clk);
        if (line_w[w] !== 1'b1 || ready_w[w] !== 1'b1) quiet = 1'b0;
      end
      chk(quiet, "R6 busy offer ignored, no extra frame", int'(quiet), 1);
    end
  endtask

  initial begin
    en_a[0] = 1'b0; en_a[1] = 1'b0;
    dat_a[0] = 8'h00; dat_a[1] = 8'h00;
    repeat (3) @(negedge clk);
    chk(line_w[0] == 1'b1 && ready_w[0] == 1'b1, "R1 reset state u0",
        int'({ready_w[0], line_w[0]}), 3);
    chk(line_w[1] == 1'b1 && ready_w[1] == 1'b1, "R1 reset state u1",
        int'({ready_w[1], line_w[1]}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_w[0] == 1'b1 && ready_w[0] == 1'b1, "R1 after release, R7 idle high",
        int'({ready_w[0], line_w[0]}), 3);
    for (int sv = 0; sv < 4; sv++) begin
      int p;
      sel = 2'(sv);
      p = 1 << (BL + sv);
      for (int i = 0; i < 6; i++) begin
        logic [7:0] b;
        case (i)
          0: b = 8'h00;
          1: b = 8'hFF;
          2: b = 8'h55;
          3: b = 8'h01;
          4: b = 8'h80;
          default: b = 8'(37 * sv + 11);
        endcase
        run_frame(0, b, p, 2, i == 2);
        run_frame(1, ~b, p, 1, i == 3);
      end
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule